// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates one virtual address at a time into a page-granular leaf page-table entry. It first rejects any address that is not a sign extension of its low `VA_BITS` bits. When translation is switched off, it returns an identity leaf straight away. When translation is on, it walks a fixed number of table levels starting at a root base. At each level it issues one 8-byte read and then decides, from the returned entry, whether to descend, finish with a leaf, or fault. A result of all zeros means fault.

A client raises `req_valid` while the walker is idle. A single-cycle `done` pulse later carries `result_pte`. The memory side is a simple request/response pair with at most one read in flight. The response may come any number of cycles after the request. Permission checks and caching of results belong to the client.

Entry layout (bits of a 64-bit word):

| Bits | Meaning |
|---|---|
| 0 | table pointer |
| 1 | valid leaf |
| 7:2 | six permission bits |
| 9:8 | spare |
| 63:10 | physical page number (PPN) |

With the default parameters:
- Pages are 8 KiB (page shift 13).
- The walk has 3 levels with 10 index bits each.
- The level index comes from address bits [42:33], [32:23] and [22:13], in that order.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `rd_req_valid` are all 0.
- R2: A request whose bits [63:VA_BITS] do not all equal bit VA_BITS-1 gives `result_pte` = 0 with `done` one cycle after acceptance, and issues no memory read.
- R3: With `vm_en` = 0, a canonical request gives the identity leaf one cycle after acceptance, with no read. The identity leaf is ((vaddr >> 13) << 10) with bit 1 set and bits 7:2 all set.
- R4: At level L (L = 0 first), the read address is the current base + 8 × ((vaddr >> (13 + (LEVELS−1−L)×10)) & 0x3FF). The first base is `root_base`.
- R5: An entry with bit 1 clear and bit 0 set, read above the last level, makes (PPN << 13) the next base and continues the walk. The same entry read at the last level is a fault.
- R6: An entry with bits 1 and 0 both clear is a fault at any level.
- R7: A leaf (bit 1 set) read at level L < LEVELS−1 is returned with (vpn & ((1 << s) − 1)) ORed into its PPN field. Here vpn = vaddr >> 13 and s = (LEVELS−1−L)×10.
- R8: A leaf, after the merge of R7, is returned only if (PPN << 13) + (vaddr & 0x1FFF) < `mem_size`, the value sampled at acceptance. Otherwise the result is 0.
- R9: `rd_req_valid` is a one-cycle pulse, with at most one read outstanding. `busy` is high from acceptance until the cycle after `done`. A request presented while busy is ignored.
- R10: `done` is a one-cycle pulse. A walk that reads k entries, each answered one cycle after its request, raises `done` 2k+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request; accepted only while idle |
| req_vaddr | input | 64 | Virtual address to translate |
| vm_en | input | 1 | Translation enable; 0 gives an identity leaf |
| root_base | input | 64 | Byte address of the top-level table |
| mem_size | input | 64 | Installed memory size in bytes |
| busy | output | 1 | Walker is not idle |
| rd_req_valid | output | 1 | Memory read request pulse |
| rd_req_addr | output | 64 | Byte address of the entry to read |
| rd_resp_valid | input | 1 | Memory read data is valid |
| rd_resp_data | input | 64 | Entry returned by memory |
| done | output | 1 | Result pulse |
| result_pte | output | 64 | Leaf entry, or 0 for a fault |

## Verification
Requests that need no read (faults and identity leaves) must show `done` in the first cycle after acceptance. Each entry read adds two cycles: one with the request out, and one in which the bench's memory answers. A walk of k reads therefore ends at cycle 2k+1. The bench drives the request on a falling edge and counts rising edges until it sees `done` on a later falling edge. It checks that count, the number of read pulses and the address of the first read against the figures worked out from the requirements. It only then compares the entry itself.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int XLEN      = 64;
    localparam int PPN_LSB   = 10;
    localparam int FLAG_TBL  = 0;
    localparam int FLAG_LEAF = 1;
    localparam int PERM_LSB  = 2;
    localparam int PERM_W    = 6;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } ptw_state_e;

    typedef enum logic [1:0] {
        EV_FAULT,
        EV_NEXT,
        EV_LEAF
    } ptw_verdict_e;

    typedef struct packed {
        ptw_verdict_e verdict;
        word_t        pte;
        word_t        next_base;
    } ptw_eval_t;

    // Upper bits must replicate the top bit of the virtual-address field.
    function automatic logic is_canonical(word_t va, int unsigned va_bits);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < XLEN; i++) begin
            if (i >= int'(va_bits) && va[i] != va[va_bits-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic word_t identity_leaf(word_t va, int unsigned pg_shift);
        word_t w;
        w = (va >> pg_shift) << PPN_LSB;
        w[FLAG_LEAF] = 1'b1;
        w[PERM_LSB +: PERM_W] = '1;
        return w;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int LEVELS    = 3,
    parameter int IDX_BITS  = 10,
    parameter int PTE_BYTES = 8,
    parameter int PG_SHIFT  = 13,
    parameter int LVL_W     = 2
) (
    input  word_t             base,
    input  word_t             vaddr,
    input  logic [LVL_W-1:0]  level,
    output word_t             entry_addr
);

    localparam word_t IDX_MASK = (word_t'(1) << IDX_BITS) - word_t'(1);

    int unsigned lvl_shift;
    word_t       idx;

    always_comb begin
        lvl_shift  = (LEVELS - 1 - int'(level)) * IDX_BITS;
        idx        = (vaddr >> (PG_SHIFT + lvl_shift)) & IDX_MASK;
        entry_addr = base + idx * word_t'(PTE_BYTES);
    end

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int LEVELS   = 3,
    parameter int IDX_BITS = 10,
    parameter int PG_SHIFT = 13,
    parameter int LVL_W    = 2
) (
    input  word_t             pte,
    input  word_t             vaddr,
    input  word_t             mem_size,
    input  logic [LVL_W-1:0]  level,
    output ptw_eval_t         ev
);

    localparam word_t OFF_MASK = (word_t'(1) << PG_SHIFT) - word_t'(1);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    int unsigned lvl_shift;
    word_t       vpn;
    word_t       low_mask;
    word_t       merged;
    word_t       paddr;

    always_comb begin
        lvl_shift = (LEVELS - 1 - int'(level)) * IDX_BITS;
        vpn       = vaddr >> PG_SHIFT;
        low_mask  = (word_t'(1) << lvl_shift) - word_t'(1);
        merged    = pte | ((vpn & low_mask) << PPN_LSB);
        paddr     = ((merged >> PPN_LSB) << PG_SHIFT) + (vaddr & OFF_MASK);

        ev.pte       = '0;
        ev.next_base = (pte >> PPN_LSB) << PG_SHIFT;
        ev.verdict   = EV_FAULT;
        if (pte[FLAG_LEAF]) begin
            if (paddr < mem_size) begin
                ev.verdict = EV_LEAF;
                ev.pte     = merged;
            end
        end else if (pte[FLAG_TBL] && level != LAST_LVL) begin
            ev.verdict = EV_NEXT;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS    = 3,
    parameter int IDX_BITS  = 10,
    parameter int PTE_BYTES = 8,
    parameter int VA_BITS   = 43
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [63:0] req_vaddr,
    input  logic        vm_en,
    input  logic [63:0] root_base,
    input  logic [63:0] mem_size,
    output logic        busy,
    output logic        rd_req_valid,
    output logic [63:0] rd_req_addr,
    input  logic        rd_resp_valid,
    input  logic [63:0] rd_resp_data,
    output logic        done,
    output logic [63:0] result_pte
);

    localparam int PG_SHIFT = VA_BITS - LEVELS * IDX_BITS;
    localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    ptw_state_e       state_q;
    word_t            va_q;
    word_t            base_q;
    word_t            size_q;
    word_t            result_q;
    logic [LVL_W-1:0] level_q;
    ptw_eval_t        ev;

    ptw_addr_gen #(
        .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PTE_BYTES(PTE_BYTES),
        .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)
    ) addr_i (
        .base(base_q), .vaddr(va_q), .level(level_q), .entry_addr(rd_req_addr)
    );

    ptw_leaf_eval #(
        .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)
    ) eval_i (
        .pte(rd_resp_data), .vaddr(va_q), .mem_size(size_q), .level(level_q), .ev(ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            base_q   <= '0;
            size_q   <= '0;
            result_q <= '0;
            level_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        base_q  <= root_base;
                        size_q  <= mem_size;
                        level_q <= '0;
                        if (!is_canonical(req_vaddr, VA_BITS)) begin
                            result_q <= '0;
                            state_q  <= ST_DONE;
                        end else if (!vm_en) begin
                            result_q <= identity_leaf(req_vaddr, PG_SHIFT);
                            state_q  <= ST_DONE;
                        end else begin
                            state_q  <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rd_resp_valid) begin
                        unique case (ev.verdict)
                            EV_NEXT: begin
                                base_q  <= ev.next_base;
                                level_q <= level_q + LVL_W'(1);
                                state_q <= ST_ISSUE;
                            end
                            EV_LEAF: begin
                                result_q <= ev.pte;
                                state_q  <= ST_DONE;
                            end
                            default: begin
                                result_q <= '0;
                                state_q  <= ST_DONE;
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign rd_req_valid = (state_q == ST_ISSUE);
    assign done         = (state_q == ST_DONE);
    assign result_pte   = result_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
#(
    parameter int VA_BITS = 43
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] req_vaddr,
    input logic        vm_en,
    input logic        busy,
    input logic        rd_req_valid,
    input logic        done,
    input logic [63:0] result_pte
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !rd_req_valid));

    p_noncanon_fault_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !is_canonical(req_vaddr, VA_BITS))
        |=> (done && result_pte == 64'd0 && !rd_req_valid));

    p_identity_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !vm_en && is_canonical(req_vaddr, VA_BITS))
        |=> (done && !rd_req_valid));

    p_read_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |=> !rd_req_valid);

    p_read_only_busy_r9: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

bind ptw_walker ptw_walker_chk #(.VA_BITS(VA_BITS)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .vm_en(vm_en), .busy(busy), .rd_req_valid(rd_req_valid), .done(done),
    .result_pte(result_pte)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        vm_en = 1'b0;
    logic [63:0] root_base = '0;
    logic [63:0] mem_size = '0;
    logic        busy;
    logic        rd_req_valid;
    logic [63:0] rd_req_addr;
    logic        rd_resp_valid = 1'b0;
    logic [63:0] rd_resp_data = '0;
    logic        done;
    logic [63:0] result_pte;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;

    always #5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .vm_en(vm_en), .root_base(root_base), .mem_size(mem_size), .busy(busy),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .done(done), .result_pte(result_pte)
    );

    // Table memory: answers one cycle after each request.
    logic [63:0] pt_mem [logic [63:0]];
    logic        pend = 1'b0;
    logic [63:0] pend_addr = '0;

    always @(negedge clk) begin
        rd_resp_valid <= 1'b0;
        if (pend) begin
            rd_resp_valid <= 1'b1;
            rd_resp_data  <= pt_mem.exists(pend_addr) ? pt_mem[pend_addr] : 64'd0;
        end
        pend      <= rd_req_valid;
        pend_addr <= rd_req_addr;
    end

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_total);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [63:0] ROOT = 64'h10000;
    localparam logic [63:0] L1T  = 64'h12000;
    localparam logic [63:0] L2T  = 64'h14000;

    function automatic logic [63:0] mk_va(int i0, int i1, int i2, int off);
        return (64'(i0) << 33) | (64'(i1) << 23) | (64'(i2) << 13) | 64'(off);
    endfunction
    function automatic logic [63:0] mk_tbl(logic [63:0] ppn);
        return (ppn << 10) | 64'h1;
    endfunction
    function automatic logic [63:0] mk_leaf(logic [63:0] ppn);
        return (ppn << 10) | 64'hFE;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issues one request and checks result, latency, read count, first address.
    task automatic run_walk(string req, logic [63:0] va, logic vm, logic [63:0] size,
                            logic [63:0] exp_pte, int exp_cyc, int exp_reads,
                            logic [63:0] exp_addr0, bit poke);
        int cyc = 0;
        int reads = 0;
        logic [63:0] addr0 = '0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; vm_en = vm; root_base = ROOT; mem_size = size;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            req_valid = 1'b0;
            if (poke && cyc == 2) begin
                req_valid = 1'b1; req_vaddr = mk_va(2, 3, 4, 0);
            end
            if (rd_req_valid) begin
                if (reads == 0) addr0 = rd_req_addr;
                reads++;
            end
        end while (!done && cyc < 50);
        req_valid = 1'b0;
        check({req, " result"}, result_pte, exp_pte);
        check({req, " latency"}, 64'(cyc), 64'(exp_cyc));
        check({req, " reads"}, 64'(reads), 64'(exp_reads));
        if (exp_reads > 0) check({req, " first address"}, addr0, exp_addr0);
        @(negedge clk);
        check({req, " idle after done"}, {63'd0, busy}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 read", {63'd0, rd_req_valid}, 64'd0);
    endtask

    task automatic t_full_walk();
        // R4 R5 R10: three reads, 7 cycles
        run_walk("R4_R5_R10 full walk", mk_va(1, 2, 3, 'h123), 1'b1, 64'd1 << 30,
                 mk_leaf(64'h40), 7, 3, ROOT + 8, 1'b0);
    endtask

    task automatic t_superpages();
        // R7 level-1 leaf: low 10 vpn bits merged
        run_walk("R7 level1 leaf", mk_va(1, 5, 7, 'h10), 1'b1, 64'd1 << 40,
                 mk_leaf(64'h400) | (64'd7 << 10), 5, 2, ROOT + 8, 1'b0);
        // R7 level-0 leaf: low 20 vpn bits merged
        run_walk("R7 level0 leaf", mk_va(2, 3, 4, 0), 1'b1, 64'd1 << 40,
                 mk_leaf(64'h100000) | (((64'd3 << 10) | 64'd4) << 10), 3, 1, ROOT + 16, 1'b0);
    endtask

    task automatic t_bounds();
        logic [63:0] lim = (64'h40 << 13) + 64'h123;
        run_walk("R8 size equal", mk_va(1, 2, 3, 'h123), 1'b1, lim, 64'd0, 7, 3, ROOT + 8, 1'b0);
        run_walk("R8 size above", mk_va(1, 2, 3, 'h123), 1'b1, lim + 1,
                 mk_leaf(64'h40), 7, 3, ROOT + 8, 1'b0);
    endtask

    task automatic t_faults();
        run_walk("R6 empty entry", mk_va(3, 0, 0, 0), 1'b1, 64'd1 << 30, 64'd0, 5, 2, ROOT + 24, 1'b0);
        run_walk("R5 pointer at last level", mk_va(1, 2, 6, 0), 1'b1, 64'd1 << 30,
                 64'd0, 7, 3, ROOT + 8, 1'b0);
        run_walk("R2 noncanonical", 64'h0000_0400_0000_0000, 1'b1, 64'd1 << 30, 64'd0, 1, 0, 0, 1'b0);
        run_walk("R2 noncanonical vm off", 64'h8000_0000_0000_0000, 1'b0, 64'd1 << 30, 64'd0, 1, 0, 0, 1'b0);
    endtask

    task automatic t_identity();
        logic [63:0] va1 = 64'hFFFF_FC00_0000_1000;
        logic [63:0] va2 = 64'h0000_0000_2468_A000;
        run_walk("R3 identity high", va1, 1'b0, 64'd0, ((va1 >> 13) << 10) | 64'hFE, 1, 0, 0, 1'b0);
        run_walk("R3 identity low", va2, 1'b0, 64'd0, ((va2 >> 13) << 10) | 64'hFE, 1, 0, 0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        // R9: second request during walk must not disturb the first
        run_walk("R9 request while busy", mk_va(1, 2, 3, 'h123), 1'b1, 64'd1 << 30,
                 mk_leaf(64'h40), 7, 3, ROOT + 8, 1'b1);
    endtask

    initial begin
        pt_mem[ROOT + 8]  = mk_tbl(64'h9);
        pt_mem[L1T + 16]  = mk_tbl(64'hA);
        pt_mem[L2T + 24]  = mk_leaf(64'h40);
        pt_mem[L1T + 40]  = mk_leaf(64'h400);
        pt_mem[ROOT + 16] = mk_leaf(64'h100000);
        pt_mem[ROOT + 24] = mk_tbl(64'h9);
        pt_mem[L2T + 48]  = mk_tbl(64'hB);
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_walk();
        t_superpages();
        t_bounds();
        t_faults();
        t_identity();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule